// File: doc/BRIEF.md
# CAN Frame Acceptance Filter with Eight-Slot Mailbox Ring

This block sits behind a CAN receiver. The receiver hands over only frames that are complete and CRC-valid. Each one arrives as a single-cycle strobe carrying the identifier, the remote-request flag, the length code and up to eight data bytes. The block decides whether to keep the frame, using a programmable mask and five filter values. Frames it keeps go into a ring of eight mailbox slots, where host software collects them one at a time.

Each slot holds a 32-bit identifier word, a 4-bit length and eight data bytes. A slot is occupied exactly when its identifier word is nonzero. The host sees the slot under the read index on `cur_id` and `cur_len`. It pulls data bytes one per strobe, and releasing the slot clears it and steps to the next one. Host-side writes set the mask and the filters. The receiver must space frame strobes at least three cycles apart.

Top module: `can_mailbox_ring`

## Requirements
- R1: While the mask register holds zero, every frame strobe is accepted.
- R2: With a nonzero mask, a frame is accepted when (identifier AND mask) equals any of the five filter values; otherwise it is discarded. Configuration select 0 writes the mask and selects 1 to 5 write filters 1 to 5.
- R3: A stored identifier word carries the identifier in bits 28:0 and the remote-request flag in bit 31. An accepted frame becomes visible on `cur_id`/`cur_len` after the second rising edge following its strobe, with length, data and identifier all appearing together.
- R4: When the slot under the write index is occupied, the accepted frame is dropped and the write index stays where it is.
- R5: The write index advances by one after each stored frame and wraps from slot 7 to slot 0.
- R6: A release strobe zeroes the current slot's identifier word, advances the read index modulo 8 and resets the byte pointer.
- R7: A byte-read strobe returns the next data byte on `rd_byte`, with `rd_byte_ok` high, one edge later. Once the stored length (capped at 8) is used up, it returns `rd_byte_ok` low and `rd_byte` zero. A header-read strobe resets the byte pointer, and `rd_byte`/`rd_byte_ok` hold between byte reads.
- R8: A length code above 8 is stored unchanged in the slot, but at most 8 data bytes can be read.
- R9: A frame with identifier 0 and the remote-request flag clear is stored as an all-zero word, so it looks like an empty slot and is lost. The write index still advances past it.
- R10: If a release and a pending store target the same slot in the same cycle, the release wins and the store completes one cycle later into the freed slot.
- R11: After reset, all slots are empty, the mask and filters are zero, both indices are 0, and `rd_byte_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is present |
| frm_id | input | 29 | Received identifier (11-bit identifiers use the low bits) |
| frm_rtr | input | 1 | Received remote-request flag |
| frm_dlc | input | 4 | Received length code |
| frm_data | input | 64 | Received data, byte 0 in bits 7:0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0 = mask, 1..5 = filter 1..5 |
| cfg_wdata | input | 32 | Configuration write value |
| hst_head_rd | input | 1 | Header read: resets the byte pointer |
| hst_byte_rd | input | 1 | Read the next data byte |
| hst_release | input | 1 | Clear the current slot and advance |
| cur_id | output | 32 | Identifier word of the slot under the read index |
| cur_len | output | 4 | Length stored in the slot under the read index |
| rd_byte | output | 8 | Last byte returned by a byte read |
| rd_byte_ok | output | 1 | Last byte read was within the stored length |

## Verification
The bench fills the ring completely and then sends one more frame, which a correct design drops. A design that overwrote an occupied slot would show the extra identifier where slot 7's frame should be. It also lines up a release with a pending store to the same slot: a design that dropped the store would leave the freed slot empty, and one that stored before the release would lose the frame. Other corners are a length code of 12 (nine byte reads, the last refused), a frame with identifier 0 that must vanish while the write index still advances, and masked filtering where a filter other than the first is the one that matches.

// File: rtl/can_mailbox_ring.sv
module can_mailbox_ring #(
  parameter int SLOTS  = 8,
  parameter int NFILT  = 5,
  parameter int NBYTES = 8,
  parameter int IDW    = 29
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frm_valid,
  input  logic [IDW-1:0]        frm_id,
  input  logic                  frm_rtr,
  input  logic [3:0]            frm_dlc,
  input  logic [8*NBYTES-1:0]   frm_data,
  input  logic                  cfg_we,
  input  logic [$clog2(NFILT+1)-1:0] cfg_sel,
  input  logic [31:0]           cfg_wdata,
  input  logic                  hst_head_rd,
  input  logic                  hst_byte_rd,
  input  logic                  hst_release,
  output logic [31:0]           cur_id,
  output logic [3:0]            cur_len,
  output logic [7:0]            rd_byte,
  output logic                  rd_byte_ok
);
  localparam int IXW  = $clog2(SLOTS);
  localparam int SELW = $clog2(NFILT+1);

  logic [31:0]         mask_r;
  logic [31:0]         filt_r [NFILT];
  logic [NFILT-1:0]    hit;
  logic                accept;

  logic                pend;
  logic [31:0]         p_word;
  logic [3:0]          p_len;
  logic [8*NBYTES-1:0] p_data;

  logic [31:0]         s_id   [SLOTS];
  logic [3:0]          s_len  [SLOTS];
  logic [8*NBYTES-1:0] s_data [SLOTS];

  logic [IXW-1:0]      wr_idx, rd_idx;
  logic [3:0]          ptr, lim;
  logic                collide, slot_full;

  wire [31:0] id32 = 32'(frm_id);

  for (genvar k = 0; k < NFILT; k++) begin : g_filt
    assign hit[k] = ((id32 & mask_r) == filt_r[k]);
  end

  assign accept    = (mask_r == 32'd0) || (|hit);
  assign cur_id    = s_id[rd_idx];
  assign cur_len   = s_len[rd_idx];
  assign lim       = (cur_len > 4'(NBYTES)) ? 4'(NBYTES) : cur_len;
  assign slot_full = (s_id[wr_idx] != 32'd0);
  assign collide   = hst_release && pend && (rd_idx == wr_idx);

  function automatic logic [IXW-1:0] step(input logic [IXW-1:0] i);
    return (int'(i) == SLOTS-1) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r     <= '0;
      pend       <= 1'b0;
      p_word     <= '0;
      p_len      <= '0;
      p_data     <= '0;
      wr_idx     <= '0;
      rd_idx     <= '0;
      ptr        <= '0;
      rd_byte    <= '0;
      rd_byte_ok <= 1'b0;
      for (int k = 0; k < NFILT; k++) filt_r[k] <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        s_id[s]   <= '0;
        s_len[s]  <= '0;
        s_data[s] <= '0;
      end
    end else begin
      if (cfg_we) begin
        if (cfg_sel == '0) mask_r <= cfg_wdata;
        for (int k = 0; k < NFILT; k++)
          if (cfg_sel == SELW'(k+1)) filt_r[k] <= cfg_wdata;
      end

      if (pend && !collide) begin
        pend <= 1'b0;
        if (!slot_full) begin
          s_len[wr_idx]  <= p_len;
          s_data[wr_idx] <= p_data;
          s_id[wr_idx]   <= p_word;
          wr_idx         <= step(wr_idx);
        end
      end

      if (frm_valid && accept) begin
        pend   <= 1'b1;
        p_word <= {frm_rtr, {(31-IDW){1'b0}}, frm_id};
        p_len  <= frm_dlc;
        p_data <= frm_data;
      end

      if (hst_release) begin
        s_id[rd_idx] <= '0;
        rd_idx       <= step(rd_idx);
        ptr          <= '0;
      end else if (hst_head_rd) begin
        ptr <= '0;
      end else if (hst_byte_rd) begin
        if (ptr < lim) begin
          rd_byte    <= s_data[rd_idx][{ptr, 3'b000} +: 8];
          rd_byte_ok <= 1'b1;
          ptr        <= ptr + 1'b1;
        end else begin
          rd_byte    <= '0;
          rd_byte_ok <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/can_mailbox_chk.sv
module can_mailbox_chk #(
  parameter int SLOTS = 8,
  parameter int IXW   = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hst_release,
  input logic           hst_head_rd,
  input logic           hst_byte_rd,
  input logic           pend,
  input logic           collide,
  input logic           slot_full,
  input logic [IXW-1:0] rd_idx,
  input logic [IXW-1:0] wr_idx,
  input logic [3:0]     ptr,
  input logic [3:0]     lim,
  input logic           rd_byte_ok
);
  AST_RELEASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hst_release |=> int'(rd_idx) == (int'($past(rd_idx)) + 1) % SLOTS); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !collide && slot_full) |=> wr_idx == $past(wr_idx)); // R4

  AST_STORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !collide && !slot_full) |=> int'(wr_idx) == (int'($past(wr_idx)) + 1) % SLOTS); // R5

  AST_DEFER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (pend && wr_idx == $past(wr_idx))); // R10

  AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_byte_rd && !hst_release && !hst_head_rd && ptr >= lim) |=> !rd_byte_ok); // R7

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_byte_rd |=> $stable(rd_byte_ok)); // R7
endmodule

bind can_mailbox_ring can_mailbox_chk #(.SLOTS(SLOTS), .IXW(IXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_release(hst_release), .hst_head_rd(hst_head_rd),
  .hst_byte_rd(hst_byte_rd), .pend(pend), .collide(collide), .slot_full(slot_full),
  .rd_idx(rd_idx), .wr_idx(wr_idx), .ptr(ptr), .lim(lim), .rd_byte_ok(rd_byte_ok)
);

// File: tb/sim_can_mailbox_ring.sv
`timescale 1ns/1ps
module sim_can_mailbox_ring;
  logic        clk = 0, rst_n = 0;
  logic        frm_valid = 0, frm_rtr = 0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hst_head_rd = 0, hst_byte_rd = 0, hst_release = 0;
  logic [31:0] cur_id;
  logic [3:0]  cur_len;
  logic [7:0]  rd_byte;
  logic        rd_byte_ok;

  int checks = 0, fails = 0;
  bit done = 0;

  can_mailbox_ring u0 (.*);

  always #10 clk = ~clk;

  // reference model
  int unsigned m_id[8];
  int          m_len[8];
  byte unsigned m_dat[8][8];
  int unsigned m_mask, m_filt[5];
  int  m_wr, m_rd, m_ptr, m_rb, m_ok;
  bit  m_pend;
  int unsigned q_word; int q_len; byte unsigned q_dat[8];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_id[s]) begin m_id[s] = 0; m_len[s] = 0; for (int b = 0; b < 8; b++) m_dat[s][b] = 0; end
      m_mask = 0; foreach (m_filt[k]) m_filt[k] = 0;
      m_wr = 0; m_rd = 0; m_ptr = 0; m_rb = 0; m_ok = 0; m_pend = 0;
    end else begin
      int lim; bit acc; bit coll;
      lim = (m_len[m_rd] > 8) ? 8 : m_len[m_rd];
      acc = (m_mask == 0);
      for (int k = 0; k < 5; k++) if ((frm_id & m_mask) == m_filt[k]) acc = 1;
      coll = hst_release && m_pend && (m_rd == m_wr);
      if (!hst_release && !hst_head_rd && hst_byte_rd) begin
        if (m_ptr < lim) begin m_rb = m_dat[m_rd][m_ptr]; m_ok = 1; m_ptr++; end
        else begin m_rb = 0; m_ok = 0; end
      end
      if (m_pend && !coll) begin
        m_pend = 0;
        if (m_id[m_wr] == 0) begin
          m_id[m_wr] = q_word; m_len[m_wr] = q_len;
          for (int b = 0; b < 8; b++) m_dat[m_wr][b] = q_dat[b];
          m_wr = (m_wr + 1) % 8;
        end
      end
      if (hst_release) begin m_id[m_rd] = 0; m_rd = (m_rd + 1) % 8; m_ptr = 0; end
      else if (hst_head_rd) m_ptr = 0;
      if (frm_valid && acc) begin
        m_pend = 1; q_word = {frm_rtr, 2'b00, frm_id}; q_len = frm_dlc;
        for (int b = 0; b < 8; b++) q_dat[b] = frm_data[8*b +: 8];
      end
      if (cfg_we) begin
        if (cfg_sel == 0) m_mask = cfg_wdata;
        else if (cfg_sel <= 5) m_filt[cfg_sel-1] = cfg_wdata;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 cur_id vs model", cur_id, m_id[m_rd]);
    chk("R8 cur_len vs model", cur_len, m_len[m_rd]);
    chk("R7 rd_byte_ok vs model", rd_byte_ok, m_ok);
    chk("R7 rd_byte vs model", rd_byte, m_rb);
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic send(logic [28:0] id, logic rtr, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk); frm_valid = 1; frm_id = id; frm_rtr = rtr; frm_dlc = dlc; frm_data = d;
    @(negedge clk); frm_valid = 0;
    idle(2);
  endtask

  task automatic cfg(logic [2:0] sel, logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic release_slot;
    @(negedge clk); hst_release = 1;
    @(negedge clk); hst_release = 0;
  endtask

  task automatic head;
    @(negedge clk); hst_head_rd = 1;
    @(negedge clk); hst_head_rd = 0;
  endtask

  task automatic rdb(string tag, int eb, int eok);
    @(negedge clk); hst_byte_rd = 1;
    @(negedge clk); hst_byte_rd = 0;
    chk(tag, rd_byte, eb); chk(tag, rd_byte_ok, eok);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk("R11 reset cur_id", cur_id, 0);
    chk("R11 reset cur_len", cur_len, 0);
    chk("R11 reset rd_byte_ok", rd_byte_ok, 0);

    send(29'h123, 0, 3, 64'h332211);
    chk("R1 zero mask accepts", cur_id, 32'h123);
    head();
    rdb("R7 byte0", 8'h11, 1); rdb("R7 byte1", 8'h22, 1); rdb("R7 byte2", 8'h33, 1);
    rdb("R7 past length", 0, 0);
    release_slot();
    chk("R6 release clears", cur_id, 0);

    send(29'h1ABCDEF0, 1, 0, 0);
    chk("R3 ext rtr word", cur_id, 32'h9ABCDEF0);
    release_slot();

    cfg(0, 32'h7F0); cfg(1, 32'h120);
    cfg(2, 32'h7F0); cfg(3, 32'h7F0); cfg(4, 32'h7F0); cfg(5, 32'h340);
    send(29'h125, 0, 1, 64'hAA);
    send(29'h555, 0, 1, 64'hBB);
    send(29'h34F, 0, 1, 64'hCC);
    chk("R2 filter1 match", cur_id, 32'h125);
    release_slot();
    chk("R2 filter5 match", cur_id, 32'h34F);
    release_slot();
    chk("R2 rejected frame absent", cur_id, 0);

    cfg(0, 0);
    send(29'h0, 0, 2, 64'h5566);
    send(29'h200, 0, 0, 0);
    chk("R9 zero-id frame lost", cur_id, 0);
    release_slot();
    chk("R9 write index advanced", cur_id, 32'h200);
    release_slot();

    send(29'h77, 0, 12, 64'hA7A6A5A4A3A2A1A0);
    chk("R8 length kept", cur_len, 12);
    head();
    for (int b = 0; b < 8; b++) rdb("R8 data byte", 8'hA0 + b, 1);
    rdb("R8 ninth byte refused", 0, 0);
    head();
    rdb("R7 header read rewinds", 8'hA0, 1);
    release_slot();

    for (int i = 0; i < 8; i++) send(29'h10 + i, 0, 0, 0);
    send(29'h18, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R5 ring order", cur_id, 32'h10 + i);
      release_slot();
    end
    chk("R4 overflow frame dropped", cur_id, 0);

    for (int i = 0; i < 8; i++) send(29'h40 + i, 0, 0, 0);
    @(negedge clk); frm_valid = 1; frm_id = 29'h50; frm_rtr = 0; frm_dlc = 0; frm_data = 0;
    @(negedge clk); frm_valid = 0; hst_release = 1;
    @(negedge clk); hst_release = 0;
    idle(2);
    chk("R10 next slot after release", cur_id, 32'h41);
    for (int i = 0; i < 7; i++) release_slot();
    chk("R10 deferred store landed", cur_id, 32'h50);
    release_slot();

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule